// File: doc/BRIEF.md
# Luma Block-Aware Noise Coring Filter

This block cleans up a stream of 8-bit luma samples, one per clock, before they go on to later video stages. A three-tap high-pass kernel measures the local detail around each sample. The magnitude of that detail is compared with a programmable threshold. In noise-reduction mode, small detail is treated as noise and a scaled part of it is removed. In sharpening mode, large detail is treated as picture content and a scaled part of it is added back. A chroma sample travels beside each luma sample and is not changed.

Compressed video sources tend to leave artefacts along a fixed horizontal block grid. The block therefore tracks each sample's position within an 8- or 16-pixel grid, counted from a line-start strobe and shifted by a programmable offset. A narrow band of pixels on either side of each grid edge uses its own gain, apart from the gain used for interior pixels. Every sample takes the same fixed pipeline delay, and a valid strobe travels with the data.

Top module: `luma_coring_filter`

## Requirements
- R1: While reset is active, and after it until the first valid sample reaches the output, `outValid`, `outLuma` and `outChroma` are all zero.
- R2: A sample driven with `inValid` high in input cycle n shows `outValid` high in cycle n+3. Input cycles with `inValid` low give `outValid` low three cycles later.
- R3: `outChroma` on a valid output equals the `inChroma` that was sent with the same sample.
- R4: The detail is d = floor((2c - l - r) / 4). Here c is the sample, l the previous input cycle's sample and r the next input cycle's sample. l is replaced by c when the previous cycle was not valid or when c carries `inLine`. r is replaced by c when the next cycle is not valid or carries `inLine`.
- R5: With `cfgSharpen`=0, a sample whose |d| is strictly less than `cfgThreshold` becomes c - floor(d*g/16). Any other sample stays at c.
- R6: With `cfgSharpen`=1, a sample whose |d| is strictly greater than `cfgThreshold` becomes c + floor(d*g/16). Any other sample stays at c.
- R7: The gain g is a 4-bit unsigned value counted in sixteenths. A gain of 0 returns c for every sample.
- R8: Every valid `outLuma` is clamped to the range 1 to 254, including samples that were not adjusted.
- R9: A sample with `inValid` and `inLine` both high has position 0. Each later valid sample has the previous valid sample's position plus one, modulo 16. Invalid cycles do not advance the position.
- R10: The grid phase is (position + `cfgOffset`) mod N, with N = 16 when `cfgBlock16`=1 and N = 8 otherwise. A sample is a border sample when its phase is below h or at least N - h. h is 1 when `cfgBorder4`=0 (2 border pixels) and 2 when `cfgBorder4`=1 (4 border pixels).
- R11: `cfgOffset` moves the grid relative to the line start as given by the phase formula in R10.
- R12: Border samples use `cfgGainBorder` as g, and interior samples use `cfgGainData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input sample valid |
| inLine | input | 1 | Marks the first sample of a line (only meaningful with inValid) |
| inLuma | input | 8 | Input luma sample |
| inChroma | input | 8 | Chroma sample carried alongside, passed through unchanged |
| cfgSharpen | input | 1 | 0 = noise reduction, 1 = sharpening |
| cfgThreshold | input | 8 | Detail magnitude threshold |
| cfgGainData | input | 4 | Gain in sixteenths for interior pixels |
| cfgGainBorder | input | 4 | Gain in sixteenths for block-border pixels |
| cfgBlock16 | input | 1 | 0 = 8-pixel grid, 1 = 16-pixel grid |
| cfgBorder4 | input | 1 | 0 = 2-pixel border, 1 = 4-pixel border |
| cfgOffset | input | 4 | Grid offset added to the pixel position |
| outValid | output | 1 | Output sample valid |
| outLuma | output | 8 | Processed luma |
| outChroma | output | 8 | Delayed chroma |

## Verification
A line start and a block border can fall on the same sample. With a zero offset, position 0 is always a border pixel. So the first sample of each line depends on two things at once: its left neighbour must be replaced by itself, and it must take the border gain rather than the interior gain. The bench sets different border and interior gains, sends back-to-back lines and lines broken by invalid gaps, and moves the offset and grid size. Each sample is judged against a behavioural model that works out the neighbour replacement and the border decision separately, so an error in either one shows up as a wrong value on that sample.

// File: rtl/lnc_pkg.sv
package lnc_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic centerValid;  // sample held in tap0 is valid
    logic useLeft;      // tap1 is a real left neighbour of tap0
    logic useRight;     // current input is a real right neighbour of tap0
    logic border;       // tap0 sample lies in the block border band
  } lncCtrl_t;
endpackage

// File: rtl/lnc_ctrl.sv
module lnc_ctrl
  import lnc_pkg::*;
#(
  parameter int POS_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inLine,
  input  logic             cfgBlock16,
  input  logic             cfgBorder4,
  input  logic [POS_W-1:0] cfgOffset,
  output lncCtrl_t         ctl
);
  localparam int BIG_N   = 2 ** POS_W;
  localparam int SMALL_N = BIG_N / 2;
  localparam logic [POS_W-1:0] BIG_LAST   = POS_W'(BIG_N - 1);
  localparam logic [POS_W-1:0] SMALL_LAST = POS_W'(SMALL_N - 1);

  logic [POS_W-1:0] posCnt, curPos, shifted, phase, blockLast, halfW;
  logic vld0, line0, vld1, border0, isBorder;

  always_comb begin
    curPos    = inLine ? '0 : posCnt;
    shifted   = curPos + cfgOffset;
    blockLast = cfgBlock16 ? BIG_LAST : SMALL_LAST;
    phase     = shifted & blockLast;
    halfW     = cfgBorder4 ? POS_W'(2) : POS_W'(1);
    isBorder  = (phase < halfW) || (phase > (blockLast - halfW));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posCnt  <= '0;
      vld0    <= 1'b0;
      line0   <= 1'b0;
      vld1    <= 1'b0;
      border0 <= 1'b0;
    end else begin
      vld0    <= inValid;
      line0   <= inValid & inLine;
      vld1    <= vld0;
      border0 <= isBorder;
      if (inValid) posCnt <= curPos + POS_W'(1);
    end
  end

  always_comb begin
    ctl.centerValid = vld0;
    ctl.useLeft     = vld1 & ~line0;
    ctl.useRight    = inValid & ~inLine;
    ctl.border      = border0;
  end
endmodule

// File: rtl/lnc_datapath.sv
module lnc_datapath
  import lnc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GAIN_W = 4,
  parameter int THR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  lncCtrl_t          ctl,
  input  logic [DATA_W-1:0] inLuma,
  input  logic [DATA_W-1:0] inChroma,
  input  logic              cfgSharpen,
  input  logic [THR_W-1:0]  cfgThreshold,
  input  logic [GAIN_W-1:0] cfgGainData,
  input  logic [GAIN_W-1:0] cfgGainBorder,
  output logic              outValid,
  output logic [DATA_W-1:0] outLuma,
  output logic [DATA_W-1:0] outChroma
);
  localparam int SUM_W  = DATA_W + 3;
  localparam int PROD_W = SUM_W + GAIN_W + 1;
  localparam int RES_W  = PROD_W + 1;
  localparam int CMP_W  = (SUM_W > THR_W) ? SUM_W : THR_W;
  localparam logic signed [RES_W-1:0] SAT_LO = RES_W'(1);
  localparam logic signed [RES_W-1:0] SAT_HI = RES_W'(2 ** DATA_W - 2);

  // Input taps
  logic [DATA_W-1:0] tap0, tap1, chr0;
  logic [DATA_W-1:0] leftS, rightS;
  logic signed [SUM_W-1:0] hpSum, detail;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tap0 <= '0;
      tap1 <= '0;
      chr0 <= '0;
    end else begin
      tap0 <= inLuma;
      tap1 <= tap0;
      chr0 <= inChroma;
    end
  end

  always_comb begin
    leftS  = ctl.useLeft  ? tap1   : tap0;
    rightS = ctl.useRight ? inLuma : tap0;
    hpSum  = $signed({2'b0, tap0, 1'b0}) - $signed({3'b0, leftS})
           - $signed({3'b0, rightS});
    detail = hpSum >>> 2;
  end

  // Detail stage
  logic aValid, aBorder;
  logic [DATA_W-1:0] aCenter, aChroma;
  logic signed [SUM_W-1:0] aDetail;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aValid  <= 1'b0;
      aBorder <= 1'b0;
      aCenter <= '0;
      aChroma <= '0;
      aDetail <= '0;
    end else begin
      aValid  <= ctl.centerValid;
      aBorder <= ctl.border;
      aCenter <= tap0;
      aChroma <= chr0;
      aDetail <= detail;
    end
  end

  // Coring and saturation
  logic signed [SUM_W-1:0]  mag;
  logic [CMP_W-1:0]         magE, thrE;
  logic [GAIN_W-1:0]        gain;
  logic signed [PROD_W-1:0] prod, adj;
  logic signed [RES_W-1:0]  centerS, adjS, res;
  logic                     apply;
  logic [DATA_W-1:0]        satLuma;

  always_comb begin
    mag     = (aDetail < 0) ? -aDetail : aDetail;
    magE    = CMP_W'($unsigned(mag));
    thrE    = CMP_W'(cfgThreshold);
    gain    = aBorder ? cfgGainBorder : cfgGainData;
    prod    = PROD_W'(aDetail) * PROD_W'($signed({1'b0, gain}));
    adj     = prod >>> GAIN_W;
    apply   = cfgSharpen ? (magE > thrE) : (magE < thrE);
    centerS = RES_W'($signed({1'b0, aCenter}));
    adjS    = RES_W'(adj);
    if (!apply)          res = centerS;
    else if (cfgSharpen) res = centerS + adjS;
    else                 res = centerS - adjS;
    if (res < SAT_LO)      satLuma = DATA_W'(SAT_LO);
    else if (res > SAT_HI) satLuma = DATA_W'(SAT_HI);
    else                   satLuma = res[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outLuma   <= '0;
      outChroma <= '0;
    end else begin
      outValid <= aValid;
      if (aValid) begin
        outLuma   <= satLuma;
        outChroma <= aChroma;
      end
    end
  end
endmodule

// File: rtl/luma_coring_filter.sv
module luma_coring_filter
  import lnc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GAIN_W = 4,
  parameter int THR_W  = 8,
  parameter int POS_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inLine,
  input  logic [DATA_W-1:0] inLuma,
  input  logic [DATA_W-1:0] inChroma,
  input  logic              cfgSharpen,
  input  logic [THR_W-1:0]  cfgThreshold,
  input  logic [GAIN_W-1:0] cfgGainData,
  input  logic [GAIN_W-1:0] cfgGainBorder,
  input  logic              cfgBlock16,
  input  logic              cfgBorder4,
  input  logic [POS_W-1:0]  cfgOffset,
  output logic              outValid,
  output logic [DATA_W-1:0] outLuma,
  output logic [DATA_W-1:0] outChroma
);
  lncCtrl_t ctl;

  lnc_ctrl #(.POS_W(POS_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLine(inLine),
    .cfgBlock16(cfgBlock16), .cfgBorder4(cfgBorder4),
    .cfgOffset(cfgOffset), .ctl(ctl)
  );

  lnc_datapath #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .THR_W(THR_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inLuma(inLuma), .inChroma(inChroma),
    .cfgSharpen(cfgSharpen), .cfgThreshold(cfgThreshold),
    .cfgGainData(cfgGainData), .cfgGainBorder(cfgGainBorder),
    .outValid(outValid), .outLuma(outLuma), .outChroma(outChroma)
  );
endmodule

// File: rtl/luma_coring_filter_chk.sv
module luma_coring_filter_chk #(
  parameter int DATA_W = 8,
  parameter int GAIN_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] inLuma,
  input logic [DATA_W-1:0] inChroma,
  input logic [GAIN_W-1:0] cfgGainData,
  input logic [GAIN_W-1:0] cfgGainBorder,
  input logic              outValid,
  input logic [DATA_W-1:0] outLuma,
  input logic [DATA_W-1:0] outChroma
);
  localparam logic [DATA_W-1:0] LO = DATA_W'(1);
  localparam logic [DATA_W-1:0] HI = DATA_W'(2 ** DATA_W - 2);

  logic [1:0] warm;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  function automatic logic [DATA_W-1:0] clampIn(input logic [DATA_W-1:0] v);
    if (v < LO) return LO;
    if (v > HI) return HI;
    return v;
  endfunction

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3) |-> (outValid == $past(inValid, 3)));

  assert_out_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((outLuma >= LO) && (outLuma <= HI)));

  assert_chroma_pass_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((warm == 2'd3) && outValid) |-> (outChroma == $past(inChroma, 3)));

  assert_zero_gain_pass_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((warm == 2'd3) && outValid && ($past(cfgGainData) == '0) &&
     ($past(cfgGainBorder) == '0)) |-> (outLuma == clampIn($past(inLuma, 3))));
endmodule

bind luma_coring_filter luma_coring_filter_chk #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inLuma(inLuma), .inChroma(inChroma),
  .cfgGainData(cfgGainData), .cfgGainBorder(cfgGainBorder),
  .outValid(outValid), .outLuma(outLuma), .outChroma(outChroma)
);

// File: tb/luma_coring_filter_tb_top.sv
`timescale 1ns/1ps
module luma_coring_filter_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inLine = 1'b0;
  logic [7:0] inLuma = '0, inChroma = '0;
  logic cfgSharpen = 1'b0;
  logic [7:0] cfgThreshold = '0;
  logic [3:0] cfgGainData = '0, cfgGainBorder = '0;
  logic cfgBlock16 = 1'b0, cfgBorder4 = 1'b0;
  logic [3:0] cfgOffset = '0;
  logic outValid;
  logic [7:0] outLuma, outChroma;

  always #4 clk = ~clk;

  luma_coring_filter dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLine(inLine),
    .inLuma(inLuma), .inChroma(inChroma), .cfgSharpen(cfgSharpen),
    .cfgThreshold(cfgThreshold), .cfgGainData(cfgGainData),
    .cfgGainBorder(cfgGainBorder), .cfgBlock16(cfgBlock16),
    .cfgBorder4(cfgBorder4), .cfgOffset(cfgOffset),
    .outValid(outValid), .outLuma(outLuma), .outChroma(outChroma)
  );

  int nChecks = 0, nFails = 0;
  int edgeIdx = 0, posCount = 0;
  int seed = 32'h1ACE5;
  string curTag = "R5";
  int hV[8], hL[8], hY[8], hC[8], hPos[8], hOff[8], hB16[8], hB4[8];
  int hSh[8], hThr[8], hGD[8], hGB[8];

  function automatic int nextRand();
    seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
    return (seed >> 8) & 16'hffff;
  endfunction

  function automatic int getV(int k);
    if (k < 0) return 0;
    return hV[k & 7];
  endfunction

  function automatic int clampI(int v);
    if (v < 1) return 1;
    if (v > 254) return 254;
    return v;
  endfunction

  // Behavioural model of the sample captured at edge i
  function automatic int expLuma(int i);
    int c, l, r, n, hw, ph, k, s, d, g, adj, mag, y;
    bit brd, apply;
    c = hY[i & 7];
    l = (getV(i - 1) != 0 && hL[i & 7] == 0) ? hY[(i - 1) & 7] : c;   // R4
    r = (getV(i + 1) != 0 && hL[(i + 1) & 7] == 0) ? hY[(i + 1) & 7] : c;
    n = hB16[i & 7] ? 16 : 8;                                          // R10
    hw = hB4[i & 7] ? 2 : 1;
    ph = (hPos[i & 7] + hOff[i & 7]) % n;                              // R11
    brd = (ph < hw) || (ph >= n - hw);
    k = (i + 2) & 7;
    s = 2 * c - l - r;
    d = s >>> 2;
    g = brd ? hGB[k] : hGD[k];                                          // R12
    adj = (d * g) >>> 4;                                                // R7
    mag = (d < 0) ? -d : d;
    apply = hSh[k] ? (mag > hThr[k]) : (mag < hThr[k]);                 // R5 R6
    y = c;
    if (apply) y = hSh[k] ? c + adj : c - adj;
    return clampI(y);                                                   // R8
  endfunction

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", tag, act, exp, edgeIdx);
    end
  endtask

  task automatic step();
    int j, p, ev;
    @(posedge clk);
    #1;
    j = edgeIdx & 7;
    hV[j] = inValid; hL[j] = inValid & inLine;
    hY[j] = inLuma;  hC[j] = inChroma;
    hOff[j] = cfgOffset; hB16[j] = cfgBlock16; hB4[j] = cfgBorder4;
    hSh[j] = cfgSharpen; hThr[j] = cfgThreshold;
    hGD[j] = cfgGainData; hGB[j] = cfgGainBorder;
    if (inValid) begin                                                  // R9
      p = inLine ? 0 : posCount;
      posCount = (p + 1) % 16;
      hPos[j] = p;
    end else hPos[j] = 0;
    if (edgeIdx >= 2) begin
      ev = getV(edgeIdx - 2);
      check("R2", outValid, ev);
      if (ev != 0) begin
        check("R3", outChroma, hC[(edgeIdx - 2) & 7]);
        check(curTag, outLuma, expLuma(edgeIdx - 2));
      end
    end
    edgeIdx++;
  endtask

  task automatic drive(bit v, bit ln, int y, int c);
    inValid = v; inLine = ln; inLuma = 8'(y); inChroma = 8'(c);
    step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0);
  endtask

  // kind 0: small noise around mid grey; 1: full range; 2: steps; 3: extremes
  task automatic runLine(int len, int kind, int gapEvery);
    int y;
    for (int i = 0; i < len; i++) begin
      case (kind)
        0: y = 120 + (nextRand() % 15);
        1: y = nextRand() % 256;
        2: y = ((i / 5) % 2) ? 200 : 40;
        default: y = (nextRand() % 2) ? 255 : 0;
      endcase
      drive(1, i == 0, y, nextRand() % 256);
      if (gapEvery > 0 && (i % gapEvery) == gapEvery - 1) drive(0, 0, 0, 0);
    end
  endtask

  task automatic setCfg(bit sh, int thr, int gd, int gb, bit b16, bit b4, int off);
    cfgSharpen = sh; cfgThreshold = 8'(thr); cfgGainData = 4'(gd);
    cfgGainBorder = 4'(gb); cfgBlock16 = b16; cfgBorder4 = b4; cfgOffset = 4'(off);
  endtask

  initial begin
    #(200000 * 8);
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      hV[i] = 0; hL[i] = 0; hY[i] = 0; hC[i] = 0; hPos[i] = 0;
    end
    repeat (4) @(posedge clk);
    #1;
    check("R1", outValid, 0);
    check("R1", outLuma, 0);
    check("R1", outChroma, 0);
    rstN = 1'b1;
    step();
    check("R1", outValid, 0);
    check("R1", outLuma, 0);

    curTag = "R5";
    setCfg(0, 8, 8, 8, 0, 0, 0);
    for (int i = 0; i < 4; i++) runLine(40, 0, 0);
    // threshold boundary: spike gives |d| equal to threshold
    cfgThreshold = 8'd4;
    drive(1, 1, 100, 1); drive(1, 0, 100, 2); drive(1, 0, 108, 3);
    drive(1, 0, 100, 4); drive(1, 0, 100, 5);
    idle(3);

    curTag = "R12";
    setCfg(0, 20, 12, 3, 0, 0, 0);
    for (int i = 0; i < 4; i++) runLine(35, 1, 0);

    curTag = "R6";
    setCfg(1, 6, 10, 5, 0, 0, 0);
    for (int i = 0; i < 3; i++) runLine(40, 2, 0);
    runLine(40, 1, 0);
    // boundary for sharpening: |d| equal to threshold stays unchanged
    cfgThreshold = 8'd4;
    drive(1, 1, 100, 9); drive(1, 0, 100, 9); drive(1, 0, 108, 9);
    drive(1, 0, 100, 9); idle(3);

    curTag = "R8";
    setCfg(1, 0, 15, 15, 0, 0, 0);
    for (int i = 0; i < 3; i++) runLine(30, 3, 0);

    curTag = "R7";
    setCfg(0, 255, 0, 0, 1, 1, 0);
    for (int i = 0; i < 2; i++) runLine(30, 3, 0);
    idle(3);

    curTag = "R10";
    setCfg(0, 40, 14, 2, 1, 1, 5);
    for (int i = 0; i < 3; i++) runLine(48, 1, 0);

    curTag = "R11";
    for (int off = 0; off < 16; off += 3) begin
      setCfg(1, 30, 2, 13, off % 2, (off / 3) % 2, off);
      runLine(33, 1, 0);
    end
    idle(4);

    curTag = "R4";
    setCfg(1, 3, 9, 15, 0, 0, 2);
    for (int i = 0; i < 3; i++) runLine(25, 1, 4);
    idle(2);

    curTag = "R9";
    setCfg(0, 60, 4, 15, 1, 0, 0);
    for (int i = 0; i < 3; i++) begin
      runLine(21, 1, 3);
      runLine(19, 1, 0);
    end
    idle(5);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule